// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Block

This block holds the per-channel control and status registers of a bus-master DMA engine inside an ATA host adapter. Each channel owns an 8-bit command byte, an 8-bit status byte and a 32-bit descriptor-table pointer. Host writes to these registers carry side effects: setting or clearing the start bit in a command byte launches or aborts a transfer on the currently selected drive of that channel, and the block emits a one-cycle start or abort pulse that carries the drive index and, for a start, the channel's descriptor pointer. The descriptor walk and the data movement live elsewhere; they report back through a completion input, which stops the channel, drops its active flag and latches its interrupt flag.

The status byte mixes three kinds of bits: a hardware-owned active flag, two sticky flags (error and interrupt) that software clears by writing one, and five plain storage bits. While a transfer runs, the direction bit of the command byte is frozen. Writes are only accepted while bus mastering is enabled, and each register accepts only its own access width; a wrong width is reported and discarded. An interrupt output follows the interrupt flags of all channels.

Top module: `bmdma_regs`

## Requirements
- R1: After reset every status byte reads 0x60 and every command byte and descriptor pointer reads 0; no pulse, error or interrupt output is high.
- R2: Command byte bit 0 is start and bit 3 is direction; while start is already 1, a command write leaves bit 3 at its previous value and stores the other written bits.
- R3: A command write that takes start from 0 to 1 sets status bit 0 (active) and, one cycle after the write edge, raises dmaStart for one cycle with dmaDrive = {channel, devSel[channel]} and dmaPtr = that channel's descriptor pointer.
- R4: A command write that takes start from 1 to 0 clears status bit 0 and raises dmaAbort for one cycle with dmaDrive of the selected drive.
- R5: Status bit 0 cannot be changed by a status write.
- R6: Status bits 1 (error) and 2 (interrupt) are cleared only by writing 1 to them while set; writing 0 keeps them and writing 1 while clear leaves them clear; status bits 7:3 store the written value.
- R7: A completion (doneValid with doneChan) clears that channel's start bit and active bit and sets its interrupt bit, taking priority over a write in the same cycle; it raises no pulse.
- R8: A pointer write stores the written word with bits 1:0 forced to 0.
- R9: Layout per channel at base channel*8: command at byte 0, status at byte 2, pointer at bytes 4..7; wrSize encodes 0 = byte, 1 = halfword, 2 = word, 3 = invalid. Command and status accept only byte writes, the pointer only word writes; any other size, or size code 3 at any offset, raises sizeErr for one cycle and changes nothing. Writes to other offsets are discarded and those bytes read 0.
- R10: While busMasterEn is 0, every write is ignored and no error is flagged.
- R11: irq is high exactly while some channel's interrupt bit is set.
- R12: A start or stop whose drive index is marked 0 in drivePresent raises driveErr for one cycle instead of the start or abort pulse; the register update still happens.
- R13: rdData returns the four register bytes at rdAddr..rdAddr+3, little-endian, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busMasterEn | input | 1 | Bus mastering enabled; gates all writes |
| devSel | input | NUM_CHAN | Selected drive (0/1) per channel |
| drivePresent | input | 2*NUM_CHAN | Per-drive presence mask, index {channel, dev} |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | ADDR_W | Byte offset of the write |
| wrSize | input | 2 | Write width code |
| wrData | input | 32 | Write data, low byte first |
| rdAddr | input | ADDR_W | Byte offset of the read |
| rdData | output | 32 | Four bytes from rdAddr upward |
| doneValid | input | 1 | Transfer completion event |
| doneChan | input | CH_W | Channel that completed |
| dmaStart | output | 1 | One-cycle transfer start pulse |
| dmaAbort | output | 1 | One-cycle transfer abort pulse |
| dmaDrive | output | CH_W+1 | Drive index for the pulse |
| dmaPtr | output | 32 | Descriptor pointer for a start |
| sizeErr | output | 1 | Wrong-width write pulse |
| driveErr | output | 1 | Start/stop aimed at an absent drive |
| irq | output | 1 | Any interrupt bit set |

## Verification
Every one of the 256 command byte values is written in sequence to one channel, so the start bit toggles in both directions and stays put in both states with the direction bit differing; this separates a correct lock from a missing lock, a lock applied when idle, and pulses issued on unchanged start. A second sweep writes all 256 status values to the other channel with completions interleaved every fourth step, telling write-one-to-clear apart from plain storage, set-on-write and a writable active flag, and following irq throughout. Directed cases cover wrong widths, writes with bus mastering off, pointer alignment, drive index formation and absent drives.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int PTR_W      = 32;
  localparam int REG_W      = 8;
  localparam int CHAN_STRIDE = 8;
  localparam int CMD_OFF    = 0;
  localparam int STS_OFF    = 2;
  localparam int PTR_OFF    = 4;
  localparam int BIT_START  = 0;
  localparam int BIT_DIR    = 3;
  localparam int BIT_ACT    = 0;
  localparam int BIT_ERR    = 1;
  localparam int BIT_INT    = 2;
  localparam logic [REG_W-1:0] STS_RESET = 8'h60;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } wrSize_e;

  typedef struct packed {
    logic             cmdWe;
    logic [REG_W-1:0] cmdVal;
    logic             stsWe;
    logic [REG_W-1:0] stsVal;
    logic             ptrWe;
    logic [PTR_W-1:0] ptrVal;
    logic             setAct;
    logic             clrAct;
  } chanStrobe_t;
endpackage

// File: rtl/bmdma_ctrl.sv
module bmdma_ctrl
  import bmdma_pkg::*;
#(
  parameter int NUM_CHAN = 2,
  localparam int CH_W   = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1,
  localparam int LOC_W  = $clog2(CHAN_STRIDE),
  localparam int ADDR_W = CH_W + LOC_W,
  localparam int DRV_W  = CH_W + 1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             busMasterEn,
  input  logic [NUM_CHAN-1:0]              devSel,
  input  logic [2*NUM_CHAN-1:0]            drivePresent,
  input  logic                             wrEn,
  input  logic [ADDR_W-1:0]                wrAddr,
  input  logic [1:0]                       wrSize,
  input  logic [PTR_W-1:0]                 wrData,
  input  logic [NUM_CHAN-1:0][REG_W-1:0]   cmdQ,
  input  logic [NUM_CHAN-1:0][REG_W-1:0]   stsQ,
  input  logic [NUM_CHAN-1:0][PTR_W-1:0]   ptrQ,
  output chanStrobe_t [NUM_CHAN-1:0]       strobes,
  output logic                             dmaStart,
  output logic                             dmaAbort,
  output logic [DRV_W-1:0]                 dmaDrive,
  output logic [PTR_W-1:0]                 dmaPtr,
  output logic                             sizeErr,
  output logic                             driveErr
);
  logic              accept;
  logic [CH_W-1:0]   chanSel;
  logic [LOC_W-1:0]  loc;
  logic              chanValid;
  logic              isByteReg;
  logic              isPtrReg;
  logic              badSize;

  assign accept    = wrEn && busMasterEn;
  assign chanSel   = wrAddr[ADDR_W-1:LOC_W];
  assign loc       = wrAddr[LOC_W-1:0];
  assign chanValid = (int'(chanSel) < NUM_CHAN);
  assign isByteReg = chanValid && (loc == LOC_W'(CMD_OFF) || loc == LOC_W'(STS_OFF));
  assign isPtrReg  = chanValid && (loc == LOC_W'(PTR_OFF));
  assign badSize   = accept && ((wrSize == SZ_BAD) ||
                                (isByteReg && wrSize != SZ_BYTE) ||
                                (isPtrReg && wrSize != SZ_WORD));

  for (genvar c = 0; c < NUM_CHAN; c++) begin : gChan
    logic        hit;
    logic [REG_W-1:0] cmdNext;
    chanStrobe_t sLocal;

    assign hit = accept && chanValid && (chanSel == CH_W'(c));

    always_comb begin
      cmdNext = wrData[REG_W-1:0];
      if (cmdQ[c][BIT_START]) cmdNext[BIT_DIR] = cmdQ[c][BIT_DIR];
      sLocal        = '0;
      sLocal.cmdWe  = hit && (loc == LOC_W'(CMD_OFF)) && (wrSize == SZ_BYTE);
      sLocal.cmdVal = cmdNext;
      sLocal.setAct = sLocal.cmdWe && !cmdQ[c][BIT_START] && cmdNext[BIT_START];
      sLocal.clrAct = sLocal.cmdWe && cmdQ[c][BIT_START] && !cmdNext[BIT_START];
      sLocal.stsWe  = hit && (loc == LOC_W'(STS_OFF)) && (wrSize == SZ_BYTE);
      sLocal.stsVal = {wrData[REG_W-1:3],
                       stsQ[c][BIT_INT] & ~wrData[BIT_INT],
                       stsQ[c][BIT_ERR] & ~wrData[BIT_ERR],
                       stsQ[c][BIT_ACT]};
      sLocal.ptrWe  = hit && (loc == LOC_W'(PTR_OFF)) && (wrSize == SZ_WORD);
      sLocal.ptrVal = {wrData[PTR_W-1:2], 2'b00};
    end

    assign strobes[c] = sLocal;
  end

  logic             startNext, abortNext, driveErrNext;
  logic [DRV_W-1:0] driveNext;
  logic [PTR_W-1:0] ptrNext;

  always_comb begin
    startNext    = 1'b0;
    abortNext    = 1'b0;
    driveErrNext = 1'b0;
    driveNext    = '0;
    ptrNext      = '0;
    for (int c = 0; c < NUM_CHAN; c++) begin
      if (strobes[c].setAct || strobes[c].clrAct) begin
        driveNext    = {CH_W'(c), devSel[c]};
        ptrNext      = ptrQ[c];
        startNext    = strobes[c].setAct && drivePresent[driveNext];
        abortNext    = strobes[c].clrAct && drivePresent[driveNext];
        driveErrNext = !drivePresent[driveNext];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dmaStart <= 1'b0;
      dmaAbort <= 1'b0;
      dmaDrive <= '0;
      dmaPtr   <= '0;
      sizeErr  <= 1'b0;
      driveErr <= 1'b0;
    end else begin
      dmaStart <= startNext;
      dmaAbort <= abortNext;
      dmaDrive <= driveNext;
      dmaPtr   <= ptrNext;
      sizeErr  <= badSize;
      driveErr <= driveErrNext;
    end
  end

  // R3, R4, R12: at most one of the pulse outputs per cycle
  assert_pulse_exclusive_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dmaStart, dmaAbort, driveErr}));

  // R9: a wrong-width write is reported one cycle later
  assert_size_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    (accept && wrSize == SZ_BAD) |=> sizeErr);
endmodule

// File: rtl/bmdma_datapath.sv
module bmdma_datapath
  import bmdma_pkg::*;
#(
  parameter int NUM_CHAN = 2,
  localparam int CH_W      = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1,
  localparam int LOC_W     = $clog2(CHAN_STRIDE),
  localparam int ADDR_W    = CH_W + LOC_W,
  localparam int IMG_BYTES = NUM_CHAN * CHAN_STRIDE
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  chanStrobe_t [NUM_CHAN-1:0]       strobes,
  input  logic                             doneValid,
  input  logic [CH_W-1:0]                  doneChan,
  input  logic [ADDR_W-1:0]                rdAddr,
  output logic [PTR_W-1:0]                 rdData,
  output logic [NUM_CHAN-1:0][REG_W-1:0]   cmdQ,
  output logic [NUM_CHAN-1:0][REG_W-1:0]   stsQ,
  output logic [NUM_CHAN-1:0][PTR_W-1:0]   ptrQ,
  output logic                             irq
);
  for (genvar c = 0; c < NUM_CHAN; c++) begin : gReg
    logic doneHit;
    logic [REG_W-1:0] cmdNext, stsNext;

    assign doneHit = doneValid && (doneChan == CH_W'(c));

    always_comb begin
      cmdNext = strobes[c].cmdWe ? strobes[c].cmdVal : cmdQ[c];
      stsNext = strobes[c].stsWe ? strobes[c].stsVal : stsQ[c];
      if (strobes[c].setAct) stsNext[BIT_ACT] = 1'b1;
      if (strobes[c].clrAct) stsNext[BIT_ACT] = 1'b0;
      if (doneHit) begin
        cmdNext[BIT_START] = 1'b0;
        stsNext[BIT_ACT]   = 1'b0;
        stsNext[BIT_INT]   = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cmdQ[c] <= '0;
        stsQ[c] <= STS_RESET;
        ptrQ[c] <= '0;
      end else begin
        cmdQ[c] <= cmdNext;
        stsQ[c] <= stsNext;
        if (strobes[c].ptrWe) ptrQ[c] <= strobes[c].ptrVal;
      end
    end

    // R2: direction bit frozen while start stays set
    assert_dir_locked_R2: assert property (@(posedge clk) disable iff (!rstN)
      ($past(cmdQ[c][BIT_START]) && cmdQ[c][BIT_START]) |-> $stable(cmdQ[c][BIT_DIR]));

    // R3: a rising start bit comes with the active flag
    assert_start_sets_active_R3: assert property (@(posedge clk) disable iff (!rstN)
      $rose(cmdQ[c][BIT_START]) |-> stsQ[c][BIT_ACT]);

    // R7: completion stops the channel and latches the interrupt
    assert_done_effect_R7: assert property (@(posedge clk) disable iff (!rstN)
      doneHit |=> (!cmdQ[c][BIT_START] && !stsQ[c][BIT_ACT] && stsQ[c][BIT_INT]));

    // R8: stored pointer is always dword aligned
    assert_ptr_aligned_R8: assert property (@(posedge clk) disable iff (!rstN)
      ptrQ[c][1:0] == 2'b00);
  end

  logic [IMG_BYTES-1:0][7:0] img;

  always_comb begin
    img = '0;
    for (int c = 0; c < NUM_CHAN; c++) begin
      img[c*CHAN_STRIDE + CMD_OFF] = cmdQ[c];
      img[c*CHAN_STRIDE + STS_OFF] = stsQ[c];
      for (int b = 0; b < PTR_W/8; b++)
        img[c*CHAN_STRIDE + PTR_OFF + b] = ptrQ[c][b*8 +: 8];
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < PTR_W/8; i++) begin
      if (int'(rdAddr) + i < IMG_BYTES)
        rdData[i*8 +: 8] = img[int'(rdAddr) + i];
    end
  end

  always_comb begin
    irq = 1'b0;
    for (int c = 0; c < NUM_CHAN; c++) irq = irq | stsQ[c][BIT_INT];
  end
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int NUM_CHAN = 2,
  localparam int CH_W   = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1,
  localparam int LOC_W  = $clog2(CHAN_STRIDE),
  localparam int ADDR_W = CH_W + LOC_W,
  localparam int DRV_W  = CH_W + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busMasterEn,
  input  logic [NUM_CHAN-1:0]   devSel,
  input  logic [2*NUM_CHAN-1:0] drivePresent,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [1:0]            wrSize,
  input  logic [PTR_W-1:0]      wrData,
  input  logic [ADDR_W-1:0]     rdAddr,
  output logic [PTR_W-1:0]      rdData,
  input  logic                  doneValid,
  input  logic [CH_W-1:0]       doneChan,
  output logic                  dmaStart,
  output logic                  dmaAbort,
  output logic [DRV_W-1:0]      dmaDrive,
  output logic [PTR_W-1:0]      dmaPtr,
  output logic                  sizeErr,
  output logic                  driveErr,
  output logic                  irq
);
  chanStrobe_t [NUM_CHAN-1:0]     strobes;
  logic [NUM_CHAN-1:0][REG_W-1:0] cmdQ;
  logic [NUM_CHAN-1:0][REG_W-1:0] stsQ;
  logic [NUM_CHAN-1:0][PTR_W-1:0] ptrQ;

  bmdma_ctrl #(.NUM_CHAN(NUM_CHAN)) u_ctrl (
    .clk(clk), .rstN(rstN), .busMasterEn(busMasterEn), .devSel(devSel),
    .drivePresent(drivePresent), .wrEn(wrEn), .wrAddr(wrAddr), .wrSize(wrSize),
    .wrData(wrData), .cmdQ(cmdQ), .stsQ(stsQ), .ptrQ(ptrQ), .strobes(strobes),
    .dmaStart(dmaStart), .dmaAbort(dmaAbort), .dmaDrive(dmaDrive), .dmaPtr(dmaPtr),
    .sizeErr(sizeErr), .driveErr(driveErr)
  );

  bmdma_datapath #(.NUM_CHAN(NUM_CHAN)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .doneValid(doneValid),
    .doneChan(doneChan), .rdAddr(rdAddr), .rdData(rdData), .cmdQ(cmdQ),
    .stsQ(stsQ), .ptrQ(ptrQ), .irq(irq)
  );

  // R10: with bus mastering off and no completion, registers hold
  assert_disabled_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busMasterEn && !doneValid) |=> ($stable(cmdQ) && $stable(stsQ) && $stable(ptrQ)));

  // R11: a completion leaves the interrupt output high
  assert_done_raises_irq_R11: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> irq);
endmodule

// File: tb/bmdma_regs_bench.sv
module bmdma_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busMasterEn = 1'b0;
  logic [1:0]  devSel = 2'b00;
  logic [3:0]  drivePresent = 4'hF;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [1:0]  wrSize = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        doneValid = 1'b0;
  logic [0:0]  doneChan = '0;
  logic        dmaStart, dmaAbort, sizeErr, driveErr, irq;
  logic [1:0]  dmaDrive;
  logic [31:0] dmaPtr;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // captured one cycle after the action edge
  logic cStart, cAbort, cSize, cDrvErr;
  logic [1:0]  cDrive;
  logic [31:0] cPtr;

  bmdma_regs u_bmdma_regs (
    .clk(clk), .rstN(rstN), .busMasterEn(busMasterEn), .devSel(devSel),
    .drivePresent(drivePresent), .wrEn(wrEn), .wrAddr(wrAddr), .wrSize(wrSize),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .doneValid(doneValid),
    .doneChan(doneChan), .dmaStart(dmaStart), .dmaAbort(dmaAbort),
    .dmaDrive(dmaDrive), .dmaPtr(dmaPtr), .sizeErr(sizeErr), .driveErr(driveErr),
    .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic capture();
    @(posedge clk);
    #1;
    cStart = dmaStart; cAbort = dmaAbort; cSize = sizeErr;
    cDrvErr = driveErr; cDrive = dmaDrive; cPtr = dmaPtr;
  endtask

  task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrSize = sz; wrData = d;
    capture();
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic done(input logic ch);
    @(negedge clk);
    doneValid = 1'b1; doneChan = ch;
    capture();
    @(negedge clk);
    doneValid = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    logic [7:0] prevCmd, expCmd, s1;

    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    rd(4'd0, v); chk("R1 ch0 cmd/sts", v, 32'h0060_0000);
    rd(4'd8, v); chk("R1 ch1 cmd/sts", v, 32'h0060_0000);
    chk("R1 outputs", {dmaStart, dmaAbort, sizeErr, driveErr, irq}, 0);
    @(negedge clk); rstN = 1'b1;
    rd(4'd4, v); chk("R1 ch0 ptr", v, 0);

    // R10: bus mastering off ignores writes
    wr(4'd0, 2'd0, 32'h01);
    chk("R10 no start", {cStart, cSize, cDrvErr}, 0);
    rd(4'd0, v); chk("R10 cmd unchanged", v, 32'h0060_0000);
    wr(4'd4, 2'd1, 32'hFFFF);
    chk("R10 no size error", cSize, 0);

    busMasterEn = 1'b1;
    // R8: pointer alignment
    wr(4'd4, 2'd2, 32'h1234_5677);
    rd(4'd4, v); chk("R8 ptr aligned", v, 32'h1234_5674);
    // R9: wrong widths
    wr(4'd4, 2'd0, 32'hFF);
    chk("R9 ptr byte write flagged", cSize, 1);
    rd(4'd4, v); chk("R9 ptr unchanged", v, 32'h1234_5674);
    wr(4'd0, 2'd1, 32'h01);
    chk("R9 cmd half write flagged", {cSize, cStart}, 2'b10);
    rd(4'd0, v); chk("R9 cmd unchanged", v, 32'h0060_0000);
    wr(4'd1, 2'd3, 32'h00);
    chk("R9 size code 3 flagged", cSize, 1);
    wr(4'd1, 2'd0, 32'hAB);
    rd(4'd0, v); chk("R13 reserved byte reads 0", v, 32'h0060_0000);

    // R3: start
    wr(4'd0, 2'd0, 32'h09);
    chk("R3 start pulse", {cStart, cAbort, cDrvErr}, 3'b100);
    chk("R3 drive", cDrive, 2'd0);
    chk("R3 ptr", cPtr, 32'h1234_5674);
    rd(4'd0, v); chk("R3 active set", v, 32'h0061_0009);
    // R2: direction locked while running
    wr(4'd0, 2'd0, 32'h01);
    chk("R2 no pulse", {cStart, cAbort}, 0);
    rd(4'd0, v); chk("R2 dir kept", v[7:0], 8'h09);
    // R5: active bit read-only
    wr(4'd2, 2'd0, 32'h60);
    rd(4'd0, v); chk("R5 active kept", v[23:16], 8'h61);
    // R4: stop
    wr(4'd0, 2'd0, 32'h00);
    chk("R4 abort pulse", {cStart, cAbort, cDrive}, 4'b0100);
    rd(4'd0, v); chk("R4 active cleared, dir locked", v, 32'h0060_0008);
    wr(4'd0, 2'd0, 32'h00);
    rd(4'd0, v); chk("R2 dir free when idle", v[7:0], 8'h00);

    // R3: channel 1 drive index
    devSel = 2'b10;
    wr(4'd12, 2'd2, 32'hABCD_EF03);
    wr(4'd8, 2'd0, 32'h01);
    chk("R3 ch1 drive index", {cStart, cDrive}, 3'b111);
    chk("R3 ch1 ptr", cPtr, 32'hABCD_EF00);
    // R7, R11: completion
    done(1'b1);
    chk("R7 no pulse on completion", {cStart, cAbort}, 0);
    rd(4'd8, v); chk("R7 completion state", v, 32'h0064_0000);
    chk("R11 irq high", irq, 1);
    // R6: W1C
    wr(4'd10, 2'd0, 32'h60);
    rd(4'd8, v); chk("R6 int kept on 0", v[23:16], 8'h64);
    wr(4'd10, 2'd0, 32'h64);
    rd(4'd8, v); chk("R6 int cleared on 1", v[23:16], 8'h60);
    chk("R11 irq low", irq, 0);
    wr(4'd10, 2'd0, 32'h06);
    rd(4'd8, v); chk("R6 err/int not settable", v[23:16], 8'h00);

    // R12: absent drive
    drivePresent = 4'b0111;
    wr(4'd8, 2'd0, 32'h01);
    chk("R12 start suppressed", {cStart, cDrvErr}, 2'b01);
    rd(4'd8, v); chk("R12 register updated", v[23:0], 24'h01_0001);
    wr(4'd8, 2'd0, 32'h00);
    chk("R12 abort suppressed", {cAbort, cDrvErr}, 2'b01);
    drivePresent = 4'hF;

    // R2, R3, R4 sweep of all command values on channel 0
    prevCmd = 8'h00;
    for (int i = 0; i < 256; i++) begin
      logic [7:0] d;
      d = 8'(i);
      expCmd = d;
      if (prevCmd[0]) expCmd[3] = prevCmd[3];
      wr(4'd0, 2'd0, {24'h0, d});
      rd(4'd0, v);
      chk("R2 sweep cmd", v[7:0], expCmd);
      chk("R3 R4 sweep pulses", {cStart, cAbort},
          {!prevCmd[0] && expCmd[0], prevCmd[0] && !expCmd[0]});
      chk("R3 sweep active", v[16], expCmd[0]);
      prevCmd = expCmd;
    end

    // R6, R7, R11 sweep of all status values on channel 1
    rd(4'd8, v); s1 = v[23:16];
    for (int i = 0; i < 256; i++) begin
      logic [7:0] d;
      d = 8'(i);
      if ((i % 4) == 0) begin
        done(1'b1);
        s1[0] = 1'b0; s1[2] = 1'b1;
      end
      wr(4'd10, 2'd0, {24'h0, d});
      s1 = {d[7:3], s1[2] & ~d[2], s1[1] & ~d[1], s1[0]};
      rd(4'd8, v);
      chk("R6 sweep status", v[23:16], s1);
      chk("R11 sweep irq", irq, s1[2]);
    end

    summary();
  end
endmodule